// File: doc/BRIEF.md
# SDRAM Read Command Sequencer

This block sits on the controller side of a four-bank single-data-rate SDRAM and turns read requests into command cycles on the memory pins. A request names a bank, a row and a starting column. The sequencer opens the row with an Activate when needed and waits out the row-to-column delay. It then issues the Read command and captures the data words that the memory returns after the CAS latency. Each captured word is presented with a valid strobe, and the last word of a burst also carries a done strobe. A request can also ask for an all-bank precharge, which closes every open row.

The sequencer keeps track of which banks are open and which row each one holds. A read to the row that is already open skips the Activate. A read to a bank holding a different row first closes all banks with a precharge-all. CAS latency and burst length are static configuration inputs that must match the memory's mode setting. In full-page mode the memory streams until it is stopped, so the sequencer ends the burst with a precharge-all after a requested number of words.

Control is one state machine:
- S_IDLE accepts a request. It goes to S_PREALL for a precharge request or a row conflict, to S_ACT for a closed bank, and to S_RCD for a row hit.
- S_PREALL issues the precharge-all. It then goes to S_ACT if a read is pending, otherwise back to S_IDLE.
- S_ACT issues the Activate and goes to S_RCD.
- S_RCD holds until the bank's delay counter expires, then goes to S_READ.
- S_READ issues the Read. A fixed-length burst then goes to S_DRAIN. A full-page burst goes to S_STREAM, or straight to S_STOP when one word is asked for.
- S_STREAM counts down the remaining command cycles and goes to S_STOP.
- S_STOP issues the terminating precharge-all and goes to S_DRAIN.
- S_DRAIN waits for the done strobe of the capture path and returns to S_IDLE.

Top module: `sdr_read_seq`

## Requirements
- R1: After reset the pins carry NOP ({ras_n,cas_n,we_n} = 111), req_ready is high, and rd_valid and rd_done are low.
- R2: Activate is driven as {ras_n,cas_n,we_n} = 011, with the bank on sd_ba and the row on sd_addr. It is only ever sent to a bank that is idle.
- R3: Read is driven as {ras_n,cas_n,we_n} = 101, with sd_addr[10] low, the bank on sd_ba and the column on sd_addr[8:0]. It is only sent to an open bank.
- R4: A Read to a bank comes at least TRCD clock cycles after the Activate of that bank.
- R5: The first word is sampled from sd_dq at the clock edge that lies cfg_cas_lat cycles after the Read edge. Later words are sampled on each following edge. Each captured word is shown on rd_data with rd_valid high in the cycle after its sampling edge.
- R6: cfg_burst codes 0, 1, 2 and 3 select fixed bursts of 1, 2, 4 and 8 words, and codes 4 to 6 act as 1. Exactly that many words are captured, and rd_done is high together with rd_valid on the last word only.
- R7: Code 7 selects full page. Exactly req_words words are captured, with 0 treated as 1. The precharge-all that ends the burst is on the pins exactly that many cycles after the Read, so the stream may wrap past the last column of the page.
- R8: Precharge-all is driven as {ras_n,cas_n,we_n} = 010 with sd_addr[10] high. It is sent for a request with req_pall high even when banks are already idle, and afterwards every bank counts as closed.
- R9: A read to the row already open in its bank is issued without a new Activate.
- R10: A read to a bank that holds a different row causes exactly one precharge-all and then one Activate before the Read.
- R11: Every cycle without a command carries NOP, and req_ready is high only while the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the SDRAM clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_pall | input | 1 | Request is a precharge-all; other fields ignored |
| req_bank | input | BANK_W | Bank of the read |
| req_row | input | ROW_W | Row of the read |
| req_col | input | COL_W | Starting column |
| req_words | input | WORDS_W | Word count for full-page bursts |
| cfg_cas_lat | input | CL_W | CAS latency in cycles, 1..CL_MAX |
| cfg_burst | input | 3 | Burst length code |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank select |
| sd_addr | output | ADDR_W | Address bus |
| sd_dq | input | DATA_W | Read data from memory |
| rd_data | output | DATA_W | Captured word |
| rd_valid | output | 1 | rd_data holds a word |
| rd_done | output | 1 | Last word of the burst |

## Verification
The hardest case to reach is a full-page burst that crosses the end of the page while a precharge stops it. The stop must fall on the exact cycle that matches the requested count, whatever the CAS latency. The stimulus starts full-page reads a few columns below the last one, with counts of 0, 1, 6 and 20 under two latencies. A memory model in the bench records the cycle of the Read and of the precharge and keeps streaming until the precharge's latency window closes, so a stop that comes early or late shows up both as a timing error and as a wrong word count. Row conflicts and row hits are reached by reading the same bank with a new row and with the old row, and the bench counts Activate and precharge commands.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;

    // {ras_n, cas_n, we_n}
    typedef enum logic [2:0] {
        CMD_NOP  = 3'b111,
        CMD_ACT  = 3'b011,
        CMD_READ = 3'b101,
        CMD_PRE  = 3'b010
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PREALL,
        S_ACT,
        S_RCD,
        S_READ,
        S_STREAM,
        S_STOP,
        S_DRAIN
    } seq_state_e;

    localparam logic [2:0] BL_FULL = 3'd7;

endpackage

// File: rtl/sdr_bank_table.sv
module sdr_bank_table #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    parameter int TRCD   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_fire,
    input  logic [BANK_W-1:0] act_bank,
    input  logic [ROW_W-1:0]  act_row,
    input  logic              pall_fire,
    input  logic [BANK_W-1:0] sel_bank,
    output logic              sel_open,
    output logic [ROW_W-1:0]  sel_row,
    output logic              sel_rcd_ok
);
    localparam int NBANK = 1 << BANK_W;
    localparam int RCD_W = $clog2(TRCD + 1);

    logic [NBANK-1:0] open_q;
    logic [ROW_W-1:0] row_q [NBANK];
    logic [RCD_W-1:0] rcd_q [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[b] <= 1'b0;
                row_q[b]  <= '0;
                rcd_q[b]  <= '0;
            end else if (pall_fire) begin
                open_q[b] <= 1'b0;
            end else if (act_fire && act_bank == BANK_W'(b)) begin
                open_q[b] <= 1'b1;
                row_q[b]  <= act_row;
                rcd_q[b]  <= RCD_W'(TRCD - 1);
            end else if (rcd_q[b] != '0) begin
                rcd_q[b] <= rcd_q[b] - 1'b1;
            end
        end
    end

    assign sel_open   = open_q[sel_bank];
    assign sel_row    = row_q[sel_bank];
    assign sel_rcd_ok = (rcd_q[sel_bank] == '0);

    p_pall_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pall_fire |=> (open_q == '0));

    p_act_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |-> !open_q[act_bank]);

endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture #(
    parameter int DATA_W = 32,
    parameter int CL_MAX = 3,
    parameter int CL_W   = 2,
    parameter int LEN_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CL_W-1:0]   cas_lat,
    input  logic [LEN_W-1:0]  len,
    input  logic [DATA_W-1:0] dq,
    output logic [DATA_W-1:0] data,
    output logic              valid,
    output logic              done
);
    logic [CL_MAX-1:0] sr_q;
    logic [CL_MAX-1:0] tap_sel;
    logic              tap;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  remain_q;

    always_comb begin
        for (int i = 0; i < CL_MAX; i++) begin
            tap_sel[i] = (int'(cas_lat) == i + 1);
        end
    end
    assign tap = |(sr_q & tap_sel);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q     <= '0;
            len_q    <= '0;
            remain_q <= '0;
            data     <= '0;
            valid    <= 1'b0;
            done     <= 1'b0;
        end else begin
            sr_q  <= (sr_q << 1) | CL_MAX'(start);
            valid <= 1'b0;
            done  <= 1'b0;
            if (start) begin
                len_q <= len;
            end
            if (tap) begin
                data     <= dq;
                valid    <= 1'b1;
                remain_q <= len_q - 1'b1;
                done     <= (len_q == LEN_W'(1));
            end else if (remain_q != '0) begin
                data     <= dq;
                valid    <= 1'b1;
                remain_q <= remain_q - 1'b1;
                done     <= (remain_q == LEN_W'(1));
            end
        end
    end

    p_done_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> valid);

endmodule

// File: rtl/sdr_read_seq.sv
module sdr_read_seq
    import sdr_rd_pkg::*;
#(
    parameter int BANK_W  = 2,
    parameter int ROW_W   = 13,
    parameter int COL_W   = 9,
    parameter int ADDR_W  = 13,
    parameter int DATA_W  = 32,
    parameter int TRCD    = 3,
    parameter int CL_MAX  = 3,
    parameter int CL_W    = 2,
    parameter int WORDS_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_pall,
    input  logic [BANK_W-1:0]  req_bank,
    input  logic [ROW_W-1:0]   req_row,
    input  logic [COL_W-1:0]   req_col,
    input  logic [WORDS_W-1:0] req_words,
    input  logic [CL_W-1:0]    cfg_cas_lat,
    input  logic [2:0]         cfg_burst,
    output logic               sd_ras_n,
    output logic               sd_cas_n,
    output logic               sd_we_n,
    output logic [BANK_W-1:0]  sd_ba,
    output logic [ADDR_W-1:0]  sd_addr,
    input  logic [DATA_W-1:0]  sd_dq,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_valid,
    output logic               rd_done
);
    localparam int AP_BIT = 10;
    localparam int SA_W   = $clog2(TRCD + 2) + 1;

    seq_state_e state_q, state_d;
    sdr_cmd_e   cmd_q, cmd_d;
    logic [BANK_W-1:0]  ba_d;
    logic [ADDR_W-1:0]  addr_d;

    logic [BANK_W-1:0]  lat_bank;
    logic [ROW_W-1:0]   lat_row;
    logic [COL_W-1:0]   lat_col;
    logic [WORDS_W-1:0] lat_words;
    logic               pend_rd_q;
    logic [WORDS_W-1:0] stream_cnt;
    logic [WORDS_W-1:0] words_eff;
    logic [WORDS_W-1:0] cap_len;
    logic               full_page;

    logic [BANK_W-1:0]  tk_sel;
    logic               tk_open;
    logic [ROW_W-1:0]   tk_row;
    logic               tk_rcd_ok;
    logic               cap_done;

    assign full_page = (cfg_burst == BL_FULL);
    assign words_eff = (lat_words == '0) ? WORDS_W'(1) : lat_words;
    assign req_ready = (state_q == S_IDLE);
    assign tk_sel    = (state_q == S_IDLE) ? req_bank : lat_bank;

    always_comb begin
        case (cfg_burst)
            3'd1:    cap_len = WORDS_W'(2);
            3'd2:    cap_len = WORDS_W'(4);
            3'd3:    cap_len = WORDS_W'(8);
            BL_FULL: cap_len = words_eff;
            default: cap_len = WORDS_W'(1);
        endcase
    end

    sdr_bank_table #(
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W),
        .TRCD   (TRCD)
    ) u_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_fire   (state_q == S_ACT),
        .act_bank   (lat_bank),
        .act_row    (lat_row),
        .pall_fire  (state_q == S_PREALL || state_q == S_STOP),
        .sel_bank   (tk_sel),
        .sel_open   (tk_open),
        .sel_row    (tk_row),
        .sel_rcd_ok (tk_rcd_ok)
    );

    sdr_rd_capture #(
        .DATA_W (DATA_W),
        .CL_MAX (CL_MAX),
        .CL_W   (CL_W),
        .LEN_W  (WORDS_W)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (cmd_q == CMD_READ),
        .cas_lat (cfg_cas_lat),
        .len     (cap_len),
        .dq      (sd_dq),
        .data    (rd_data),
        .valid   (rd_valid),
        .done    (cap_done)
    );
    assign rd_done = cap_done;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    if (req_pall)                state_d = S_PREALL;
                    else if (!tk_open)           state_d = S_ACT;
                    else if (tk_row == req_row)  state_d = S_RCD;
                    else                         state_d = S_PREALL;
                end
            end
            S_PREALL: state_d = pend_rd_q ? S_ACT : S_IDLE;
            S_ACT:    state_d = S_RCD;
            S_RCD:    if (tk_rcd_ok) state_d = S_READ;
            S_READ: begin
                if (!full_page)                    state_d = S_DRAIN;
                else if (words_eff == WORDS_W'(1)) state_d = S_STOP;
                else                               state_d = S_STREAM;
            end
            S_STREAM: if (stream_cnt == WORDS_W'(1)) state_d = S_STOP;
            S_STOP:   state_d = S_DRAIN;
            S_DRAIN:  if (cap_done) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register and request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            lat_bank   <= '0;
            lat_row    <= '0;
            lat_col    <= '0;
            lat_words  <= '0;
            pend_rd_q  <= 1'b0;
            stream_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && req_valid) begin
                lat_bank  <= req_bank;
                lat_row   <= req_row;
                lat_col   <= req_col;
                lat_words <= req_words;
                pend_rd_q <= !req_pall;
            end
            if (state_q == S_READ) begin
                stream_cnt <= words_eff - 1'b1;
            end else if (state_q == S_STREAM) begin
                stream_cnt <= stream_cnt - 1'b1;
            end
        end
    end

    // command outputs
    always_comb begin
        cmd_d  = CMD_NOP;
        ba_d   = '0;
        addr_d = '0;
        unique case (state_q)
            S_PREALL, S_STOP: begin
                cmd_d          = CMD_PRE;
                addr_d[AP_BIT] = 1'b1;
            end
            S_ACT: begin
                cmd_d              = CMD_ACT;
                ba_d               = lat_bank;
                addr_d[ROW_W-1:0]  = lat_row;
            end
            S_READ: begin
                cmd_d              = CMD_READ;
                ba_d               = lat_bank;
                addr_d[COL_W-1:0]  = lat_col;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= CMD_NOP;
            sd_ba   <= '0;
            sd_addr <= '0;
        end else begin
            cmd_q   <= cmd_d;
            sd_ba   <= ba_d;
            sd_addr <= addr_d;
        end
    end
    assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

    // cycles since the last Activate on the pins
    logic [SA_W-1:0]   since_act;
    logic [BANK_W-1:0] act_ba_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act <= '1;
            act_ba_q  <= '0;
        end else if (cmd_q == CMD_ACT) begin
            since_act <= SA_W'(1);
            act_ba_q  <= sd_ba;
        end else if (since_act != '1) begin
            since_act <= since_act + 1'b1;
        end
    end

    p_trcd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_READ && sd_ba == act_ba_q) |-> since_act >= SA_W'(TRCD));

    p_read_a10_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_READ) |-> !sd_addr[AP_BIT]);

    p_pall_a10_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_PRE) |-> sd_addr[AP_BIT]);

    p_legal_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_q inside {CMD_NOP, CMD_ACT, CMD_READ, CMD_PRE});

    p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready);

endmodule

// File: tb/sdr_read_seq_test.sv
`timescale 1ns/1ps
module sdr_read_seq_test;
    localparam int TRCD = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_pall;
    logic        req_ready;
    logic [1:0]  req_bank;
    logic [12:0] req_row;
    logic [8:0]  req_col;
    logic [9:0]  req_words;
    logic [1:0]  cfg_cas_lat;
    logic [2:0]  cfg_burst;
    logic        sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;
    logic [31:0] sd_dq = 32'hDEADBEEF;
    logic [31:0] rd_data;
    logic        rd_valid, rd_done;

    always #4 clk = ~clk;

    sdr_read_seq #(.TRCD(TRCD)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_pall(req_pall),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_words(req_words),
        .cfg_cas_lat(cfg_cas_lat), .cfg_burst(cfg_burst),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq(sd_dq),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_done(rd_done)
    );

    int checks = 0;
    int failures = 0;

    function automatic void chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endfunction

    function automatic logic [31:0] pat(int b, int r, int c);
        return {b[1:0], r[12:0], c[8:0], 8'hA5};
    endfunction

    // ---------------- SDRAM model ----------------
    int  e = 0;
    bit  mopen [4];
    int  mrow  [4];
    int  act_e [4];
    int  n_act = 0, n_pre = 0;
    int  rd_start = -100, rd_len = 0, rd_stop = 0, rd_e = 0;
    int  rd_b = 0, rd_r = 0, rd_c = 0;
    bit  rd_fp = 0;
    int  fp_n = 1;
    localparam int BIG = 1 << 30;

    always @(posedge clk) begin
        int idx, c, bl;
        e++;
        if (rst_n) begin
            case ({sd_ras_n, sd_cas_n, sd_we_n})
                3'b011: begin
                    n_act++;
                    chk(!mopen[sd_ba], "R2", "activate to open bank", mopen[sd_ba], 0);
                    mopen[sd_ba] = 1;
                    mrow[sd_ba]  = int'(sd_addr);
                    act_e[sd_ba] = e;
                end
                3'b101: begin
                    chk(sd_addr[10] == 1'b0, "R3", "read A10", sd_addr[10], 0);
                    chk(mopen[sd_ba], "R3", "read to closed bank", mopen[sd_ba], 1);
                    chk(e - act_e[sd_ba] >= TRCD, "R4", "act-to-read cycles", e - act_e[sd_ba], TRCD);
                    case (cfg_burst)
                        3'd1: bl = 2;
                        3'd2: bl = 4;
                        3'd3: bl = 8;
                        default: bl = 1;
                    endcase
                    rd_fp    = (cfg_burst == 3'd7);
                    rd_len   = rd_fp ? BIG : bl;
                    rd_stop  = BIG;
                    rd_start = e + int'(cfg_cas_lat);
                    rd_e     = e;
                    rd_b     = int'(sd_ba);
                    rd_r     = mrow[sd_ba];
                    rd_c     = int'(sd_addr[8:0]);
                end
                3'b010: begin
                    n_pre++;
                    chk(sd_addr[10] == 1'b1, "R8", "precharge A10", sd_addr[10], 1);
                    for (int b = 0; b < 4; b++) mopen[b] = 0;
                    if (rd_fp && rd_stop == BIG) begin
                        chk(e - rd_e == fp_n, "R7", "read-to-stop cycles", e - rd_e, fp_n);
                        rd_stop = e + int'(cfg_cas_lat) - 1;
                    end
                end
                3'b111: ;
                default: chk(0, "R11", "illegal command", {sd_ras_n, sd_cas_n, sd_we_n}, 7);
            endcase
        end
        idx = e + 1 - rd_start;
        if (idx >= 0 && idx < rd_len && e + 1 <= rd_stop) begin
            if (rd_fp) c = (rd_c + idx) % 512;
            else       c = (rd_c & ~(rd_len - 1)) | ((rd_c + idx) & (rd_len - 1));
            sd_dq <= pat(rd_b, rd_r, c);
        end else begin
            sd_dq <= 32'hDEADBEEF;
        end
    end

    // ---------------- scoreboard ----------------
    logic [31:0] exp_q [$];
    int          len_q [$];
    int          seen = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R6", "unexpected word", rd_data, 0);
                end else begin
                    // R5: word captured on the right edge carries the right column
                    chk(rd_data == exp_q[0], "R5", "read data", rd_data, exp_q[0]);
                    void'(exp_q.pop_front());
                end
                seen++;
            end
            if (rd_done) begin
                chk(rd_valid, "R6", "done without valid", rd_valid, 1);
                if (len_q.size() == 0) begin
                    chk(0, "R6", "unexpected done", seen, 0);
                end else begin
                    chk(seen == len_q[0], "R6", "words per burst", seen, len_q[0]);
                    void'(len_q.pop_front());
                end
                seen = 0;
            end
        end
    end

    // ---------------- driver ----------------
    task automatic send(bit pall, int b, int r, int c, int w);
        @(negedge clk);
        req_valid = 1; req_pall = pall;
        req_bank = 2'(b); req_row = 13'(r); req_col = 9'(c); req_words = 10'(w);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0; req_pall = 0;
        chk(!req_ready, "R11", "ready while busy", req_ready, 0);
    endtask

    task automatic do_read(int b, int r, int c, int w);
        int n, col;
        if (cfg_burst == 3'd7) n = (w == 0) ? 1 : w;
        else if (cfg_burst == 3'd1) n = 2;
        else if (cfg_burst == 3'd2) n = 4;
        else if (cfg_burst == 3'd3) n = 8;
        else n = 1;
        fp_n = n;
        for (int i = 0; i < n; i++) begin
            if (cfg_burst == 3'd7) col = (c + i) % 512;
            else col = (c & ~(n - 1)) | ((c + i) & (n - 1));
            exp_q.push_back(pat(b, r, col));
        end
        len_q.push_back(n);
        send(0, b, r, c, w);
        while (len_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_pall();
        send(1, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
    endtask

    bit finished = 0;

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int a0, p0;
        rst_n = 0; req_valid = 0; req_pall = 0;
        req_bank = 0; req_row = 0; req_col = 0; req_words = 0;
        cfg_cas_lat = 2'd2; cfg_burst = 3'd2;
        repeat (5) @(negedge clk);
        chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R1", "reset command", {sd_ras_n, sd_cas_n, sd_we_n}, 7);
        chk(req_ready == 1, "R1", "reset ready", req_ready, 1);
        chk(rd_valid == 0 && rd_done == 0, "R1", "reset strobes", {rd_valid, rd_done}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R2 R3 R5 R6: closed bank, burst of 4, CL 2
        a0 = n_act;
        do_read(0, 5, 8, 0);
        chk(n_act == a0 + 1, "R2", "activate count", n_act, a0 + 1);

        // R9: row hit, no activate; burst wraps inside its block
        a0 = n_act;
        do_read(0, 5, 13, 0);
        chk(n_act == a0, "R9", "activate count on hit", n_act, a0);

        // R6: burst of 8, CL 3
        cfg_cas_lat = 2'd3; cfg_burst = 3'd3;
        do_read(1, 100, 3, 0);
        // R6: burst of 1 and burst of 2, and reserved code 5 acting as 1
        cfg_burst = 3'd0;
        do_read(2, 33, 17, 0);
        cfg_burst = 3'd1; cfg_cas_lat = 2'd2;
        do_read(3, 4095, 511, 0);
        cfg_burst = 3'd5;
        do_read(3, 4095, 40, 0);

        // R10: different row on open bank 0
        cfg_burst = 3'd2;
        a0 = n_act; p0 = n_pre;
        do_read(0, 77, 2, 0);
        chk(n_pre == p0 + 1, "R10", "precharge count on conflict", n_pre, p0 + 1);
        chk(n_act == a0 + 1, "R10", "activate count on conflict", n_act, a0 + 1);

        // R8: explicit precharge-all, then bank 1 needs a fresh activate
        p0 = n_pre;
        do_pall();
        chk(n_pre == p0 + 1, "R8", "precharge count", n_pre, p0 + 1);
        p0 = n_pre;
        do_pall();
        chk(n_pre == p0 + 1, "R8", "precharge with all idle", n_pre, p0 + 1);
        a0 = n_act;
        do_read(1, 100, 6, 0);
        chk(n_act == a0 + 1, "R8", "bank closed after precharge", n_act, a0 + 1);

        // R7: full page with wrap past the last column
        cfg_burst = 3'd7;
        do_read(2, 9, 509, 6);
        do_read(2, 9, 511, 1);
        do_read(2, 9, 100, 0);
        cfg_cas_lat = 2'd3;
        do_read(3, 12, 500, 20);

        // R11: idle cycles carry NOP with ready high
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R11", "idle command", {sd_ras_n, sd_cas_n, sd_we_n}, 7);
            chk(req_ready == 1, "R11", "idle ready", req_ready, 1);
        end
        chk(exp_q.size() == 0, "R6", "words left over", exp_q.size(), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule